// File: doc/BRIEF.md
# Printer Port Register Emulator

This block is the register file of a classic unidirectional/bidirectional printer port, seen by a host through a small byte-wide register bus, together with a behavioural model of the printer on the far side of the cable. The host writes a byte into the data register, then toggles the strobe line in the control register. The virtual printer accepts the byte on the low-to-high strobe transition and hands it out on an 8-bit valid/ready stream. The busy and acknowledge lines then move through their handshake. This handshake is not timed. It advances one step on every read of the status register, so a polling driver sees the full sequence without waiting.

The control register also carries an initialise line and a select line that gate everything else. Writing initialise low puts the printer into its ready state. With both lines high, the strobe bit decides whether a byte is taken or an interrupt is requested. The interrupt is a registered level. A status read clears it. For reverse-direction transfers, an external load strobe fills an input latch, and data reads return that latch while the direction bit is set.

The bus is single-cycle. `bus_rdata` is combinational from the register state while a read is presented, and every side effect of an access takes place at the rising clock edge that ends it.

Top module: `prn_port_emu`

## Requirements
- R1: Only `bus_addr[2:0]` is decoded. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF. A write to offsets 1 and 3 to 7 changes no register.
- R2: After reset, the data latches read 0xFF, status reads 0xD9 and control reads 0xCC. `irq` and `out_valid` are low.
- R3: Control bit fields are: 5 direction (1 = input), 4 interrupt enable, 3 select, 2 initialise, 1 auto-linefeed, 0 strobe. Every control write stores the written value with bits 7:6 forced to 1, and a control read returns the stored value.
- R4: Status bit fields are: 7 not-busy, 6 acknowledge, 5 paper-out, 4 online, 3 not-error, 0 timeout. A control write whose initialise bit is 0 loads status with 0xD8.
- R5: A control write with initialise = 1, select = 1 and strobe = 1 clears status bit 7. If the previously stored strobe bit was 0, the current data byte is also emitted.
- R6: A control write with initialise = 1, select = 1 and strobe = 0 makes the interrupt pending when the previously stored control has interrupt enable set. `irq` is high from the next cycle.
- R7: A status read returns the status as it was before the read, clears the pending interrupt, and drives `irq` low from the next cycle.
- R8: On a status read with status bit 7 = 0 and stored strobe = 0, an acknowledge bit of 1 is cleared. An acknowledge bit of 0 causes bits 7 and 6 to both be set. In any other case the read leaves status unchanged.
- R9: A data read returns the input latch when control bit 5 is 1, and the last written data byte otherwise.
- R10: A cycle with `rev_load` high loads `rev_data` into the input latch. A read in that same cycle still returns the old value.
- R11: An emitted byte appears on `out_data` with `out_valid` high from the next cycle. It is held stable until a cycle with `out_ready` high. An emit that occurs while `out_valid` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access presented this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read access |
| rev_load | input | 1 | Load the input latch |
| rev_data | input | 8 | Reverse-direction data for the input latch |
| out_valid | output | 1 | Accepted printer byte available |
| out_data | output | 8 | Accepted printer byte |
| out_ready | input | 1 | Consumer takes the byte |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest state to reach is the acknowledge toggle. It needs busy cleared by a rising strobe, then a second control write that lowers the stored strobe while initialise and select stay high. Only after that do status reads flip acknowledge, and any write with initialise low in between resets the sequence. Two measures get the stimulus there. The random control writes set initialise and select most of the time and leave strobe and interrupt enable free. A directed run also walks the whole strobe, interrupt, clear and acknowledge sequence, and it stalls the consumer so that a second emit meets a held byte.

// File: rtl/prn_pkg.sv
package prn_pkg;

  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  // control field positions
  localparam int C_DIR   = 5;
  localparam int C_INTEN = 4;
  localparam int C_SEL   = 3;
  localparam int C_INIT  = 2;
  localparam int C_STB   = 0;

  // status field positions
  localparam int S_NBUSY = 7;
  localparam int S_ACK   = 6;

  localparam logic [BYTE_W-1:0] CTRL_FIXED  = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RST    = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_RST    = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_READY  = 8'hD8;
  localparam logic [BYTE_W-1:0] DATA_RST    = 8'hFF;
  localparam logic [BYTE_W-1:0] UNMAPPED_RD = 8'hFF;

  // value actually stored by a control write
  function automatic logic [BYTE_W-1:0] ctrl_store(input logic [BYTE_W-1:0] v);
    return v | CTRL_FIXED;
  endfunction

  // status after a status read: one handshake step when idle-low busy and strobe low
  function automatic logic [BYTE_W-1:0] stat_after_read(input logic [BYTE_W-1:0] st,
                                                       input logic stb);
    logic [BYTE_W-1:0] r;
    r = st;
    if (!st[S_NBUSY] && !stb) begin
      if (st[S_ACK]) r[S_ACK] = 1'b0;
      else begin
        r[S_ACK]   = 1'b1;
        r[S_NBUSY] = 1'b1;
      end
    end
    return r;
  endfunction

  // data register read source
  function automatic logic [BYTE_W-1:0] data_view(input logic dir,
                                                 input logic [BYTE_W-1:0] in_latch,
                                                 input logic [BYTE_W-1:0] out_latch);
    return dir ? in_latch : out_latch;
  endfunction

endpackage

// File: rtl/prn_regs.sv
module prn_regs
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rev_load,
  input  logic [BYTE_W-1:0] rev_data,
  output logic              emit_req,
  output logic [BYTE_W-1:0] emit_byte,
  output logic              irq_eval,
  output logic              pend_next
);

  logic [BYTE_W-1:0] data_out_q, data_in_q, stat_q, ctrl_q;
  logic              pend_q;

  // named access events
  logic acc_wr, acc_rd, wr_data, wr_ctrl, rd_stat;
  assign acc_wr  = bus_sel &  bus_we;
  assign acc_rd  = bus_sel & ~bus_we;
  assign wr_data = acc_wr && (bus_addr == OFS_DATA);
  assign wr_ctrl = acc_wr && (bus_addr == OFS_CTRL);
  assign rd_stat = acc_rd && (bus_addr == OFS_STAT);

  logic [BYTE_W-1:0] ctrl_new;
  logic ctrl_reset_evt, ctrl_gate, strobe_hi_evt, raise_evt;
  assign ctrl_new       = ctrl_store(bus_wdata);
  assign ctrl_reset_evt = wr_ctrl && !ctrl_new[C_INIT];
  assign ctrl_gate      = wr_ctrl && ctrl_new[C_INIT] && ctrl_new[C_SEL];
  assign strobe_hi_evt  = ctrl_gate && ctrl_new[C_STB];
  assign raise_evt      = ctrl_gate && !ctrl_new[C_STB] && ctrl_q[C_INTEN];

  assign emit_req  = strobe_hi_evt && !ctrl_q[C_STB];
  assign emit_byte = data_out_q;
  assign irq_eval  = wr_data | wr_ctrl | rd_stat;

  always_comb begin
    pend_next = pend_q;
    if (rd_stat)        pend_next = 1'b0;
    else if (raise_evt) pend_next = 1'b1;
  end

  logic [BYTE_W-1:0] stat_next;
  always_comb begin
    stat_next = stat_q;
    if (rd_stat)             stat_next = stat_after_read(stat_q, ctrl_q[C_STB]);
    else if (ctrl_reset_evt) stat_next = STAT_READY;
    else if (strobe_hi_evt)  stat_next[S_NBUSY] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out_q <= DATA_RST;
      data_in_q  <= DATA_RST;
      stat_q     <= STAT_RST;
      ctrl_q     <= CTRL_RST;
      pend_q     <= 1'b0;
    end else begin
      if (wr_data) data_out_q <= bus_wdata;
      if (wr_ctrl) ctrl_q     <= ctrl_new;
      if (rev_load) data_in_q <= rev_data;
      stat_q <= stat_next;
      pend_q <= pend_next;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: bus_rdata = data_view(ctrl_q[C_DIR], data_in_q, data_out_q);
      OFS_STAT: bus_rdata = stat_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = UNMAPPED_RD;
    endcase
  end

  // R1: offsets above control read as all ones
  a_r1_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && bus_addr > OFS_CTRL) |-> (bus_rdata == UNMAPPED_RD));

  // R3: fixed control bits never drop
  a_r3_ctrl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:6] == 2'b11);

  // R4: initialise low puts the printer in its ready state
  a_r4_init_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[C_INIT]) |=> (stat_q == STAT_READY));

  // R5: a rising strobe under init/select leaves busy asserted (bit low)
  a_r5_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[C_INIT] && bus_wdata[C_SEL] && bus_wdata[C_STB])
      |=> !stat_q[S_NBUSY]);

  // R7: a status read leaves nothing pending
  a_r7_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> !pend_q);

  // R8: acknowledge drops on the first polling read
  a_r8_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !stat_q[S_NBUSY] && !ctrl_q[C_STB] && stat_q[S_ACK])
      |=> (!stat_q[S_ACK] && !stat_q[S_NBUSY]));

endmodule

// File: rtl/prn_stream.sv
module prn_stream
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit_req,
  input  logic [BYTE_W-1:0] emit_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);

  logic take_evt, drain_evt;
  assign take_evt  = emit_req && !out_valid;
  assign drain_evt = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take_evt) begin
      out_valid <= 1'b1;
      out_data  <= emit_byte;
    end else if (drain_evt) begin
      out_valid <= 1'b0;
    end
  end

  // R11: a byte not taken stays put
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/prn_irq_line.sv
module prn_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_eval,
  input  logic pend_next,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (irq_eval) irq <= pend_next;
  end

endmodule

// File: rtl/prn_port_emu.sv
module prn_port_emu
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rev_load,
  input  logic [BYTE_W-1:0] rev_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              irq
);

  logic              emit_req;
  logic [BYTE_W-1:0] emit_byte;
  logic              irq_eval;
  logic              pend_next;

  prn_regs u_regs (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .rev_load, .rev_data, .emit_req, .emit_byte, .irq_eval, .pend_next
  );

  prn_stream u_stream (
    .clk, .rst_n, .emit_req, .emit_byte, .out_valid, .out_data, .out_ready
  );

  prn_irq_line u_irq (
    .clk, .rst_n, .irq_eval, .pend_next, .irq
  );

  // R7: interrupt request falls after any status read
  a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == OFS_STAT) |=> !irq);

  // R6: a stored-enable strobe-low write under init/select raises the request
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_CTRL && bus_wdata[C_INIT] && bus_wdata[C_SEL]
     && !bus_wdata[C_STB] && $past(1'b1) && bus_rdata != 8'h00 && u_regs.ctrl_q[C_INTEN]) |=> irq);

endmodule

// File: tb/prn_port_emu_test.sv
module prn_port_emu_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rev_load = 1'b0;
  logic [7:0] rev_data = '0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic       irq;

  always #5 clk = ~clk;

  prn_port_emu uut (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .rev_load, .rev_data, .out_valid, .out_data, .out_ready, .irq
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // independent reference state
  logic [7:0] m_wr, m_in, m_st, m_ct, m_od;
  logic       m_pend, m_irq, m_ov;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    if (a == 3'd0) return m_ct[5] ? m_in : m_wr;
    if (a == 3'd1) return m_st;
    if (a == 3'd2) return m_ct;
    return 8'hFF;
  endfunction

  // status handshake step, written as a table of (busy_n, ack)
  function automatic logic [7:0] exp_poll(input logic [7:0] s, input logic stb);
    if (stb) return s;
    case ({s[7], s[6]})
      2'b01:   return {2'b00, s[5:0]};
      2'b00:   return {2'b11, s[5:0]};
      default: return s;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    if (a == 3'd0) return "R9";
    if (a == 3'd1) return "R7/R8";
    if (a == 3'd2) return "R3";
    return "R1";
  endfunction

  task automatic model_reset();
    m_wr = 8'hFF; m_in = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC;
    m_pend = 0; m_irq = 0; m_ov = 0; m_od = 8'h00;
  endtask

  task automatic model_step(input logic sel, input logic we, input logic [2:0] a,
                            input logic [7:0] wd, input logic ld, input logic [7:0] rd,
                            input logic rdy);
    logic [7:0] nc;
    logic emit, eval;
    emit = 0; eval = 0;
    if (sel && we && a == 3'd0) begin m_wr_next(wd); eval = 1; end
    if (sel && we && a == 3'd2) begin
      nc = {2'b11, wd[5:0]};
      eval = 1;
      if (!nc[2]) m_st = 8'hD8;
      else if (nc[3]) begin
        if (nc[0]) begin
          m_st[7] = 1'b0;
          if (!m_ct[0]) emit = 1;
        end else if (m_ct[4]) m_pend = 1;
      end
      m_ct = nc;
    end
    if (sel && !we && a == 3'd1) begin
      eval = 1;
      m_pend = 0;
      m_st = exp_poll(m_st, m_ct[0]);
    end
    if (eval) m_irq = m_pend;
    if (ld) m_in = rd;
    if (emit && !m_ov) begin m_ov = 1; m_od = m_wr; end
    else if (m_ov && rdy) m_ov = 0;
  endtask

  // data write applied after emit decision (a data write never shares a cycle with emit)
  task automatic m_wr_next(input logic [7:0] wd);
    m_wr = wd;
  endtask

  // one bus cycle: drive after falling edge, check before rising edge, then advance the model
  task automatic cyc(input logic sel, input logic we, input logic [2:0] a,
                     input logic [7:0] wd, input logic ld, input logic [7:0] rd,
                     input logic rdy, input string tag);
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    rev_load = ld; rev_data = rd; out_ready = rdy;
    #2;
    if (sel && !we) chk(bus_rdata, exp_read(a), (tag == "") ? read_tag(a) : tag);
    chk({7'd0, irq}, {7'd0, m_irq}, "R6/R7 irq");
    chk({7'd0, out_valid}, {7'd0, m_ov}, "R11 valid");
    if (m_ov) chk(out_data, m_od, "R5/R11 data");
    model_step(sel, we, a, wd, ld, rd, rdy);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    cyc(1, 1, a, d, 0, 8'h00, 0, tag);
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    cyc(1, 0, a, 8'h00, 0, 8'h00, 0, tag);
  endtask

  initial begin
    int seed;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    rd(3'd1, "R2 status");
    rd(3'd2, "R2 control");
    rd(3'd0, "R2 data");
    chk(bus_rdata, 8'hFF, "R2 data literal");

    // R1: unmapped offsets and ignored status write
    rd(3'd5, "R1 unmapped");
    wr(3'd1, 8'h00, "R1");
    wr(3'd6, 8'h00, "R1");
    rd(3'd1, "R1 status untouched");

    // R3/R4: init low
    wr(3'd2, 8'h00, "R4");
    rd(3'd2, "R3 forced bits");
    rd(3'd1, "R4 ready status");

    // R5: byte accepted on rising strobe
    wr(3'd2, 8'h0C, "R5");
    wr(3'd0, 8'hA5, "R5");
    wr(3'd2, 8'h0D, "R5");
    rd(3'd1, "R5 busy cleared");
    // R6: interrupt enable stored, then strobe-low write raises
    wr(3'd2, 8'h1C, "R6");
    wr(3'd2, 8'h1C, "R6");
    cyc(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, "R6");
    // R8: polling sequence
    rd(3'd1, "R8 step0");
    rd(3'd1, "R8 step1");
    rd(3'd1, "R8 step2");
    // R11: second emit dropped while first byte held
    wr(3'd0, 8'h3C, "R11");
    wr(3'd2, 8'h1D, "R11");
    cyc(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, "R11");
    cyc(0, 0, 3'd0, 8'h00, 0, 8'h00, 1, "R11");
    cyc(0, 0, 3'd0, 8'h00, 0, 8'h00, 0, "R11");
    // R10/R9: reverse latch
    cyc(1, 0, 3'd0, 8'h00, 1, 8'h5A, 0, "R10 old value");
    wr(3'd2, 8'h2C, "R9");
    rd(3'd0, "R10 latch");
    wr(3'd2, 8'h0C, "R9");
    rd(3'd0, "R9 written byte");

    // random phase
    seed = 32'h1d2c3b;
    void'($urandom(seed));
    for (int i = 0; i < 4000; i++) begin
      logic s, w, l, y;
      logic [2:0] a;
      logic [7:0] d;
      s = ($urandom % 4) != 0;
      w = $urandom % 2;
      a = (($urandom % 5) == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
      d = 8'($urandom);
      if (w && a == 3'd2 && ($urandom % 4) != 0) d = d | 8'h0C;
      l = ($urandom % 8) == 0;
      y = ($urandom % 3) == 0;
      cyc(s, w, a, d, l, 8'($urandom), y, "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 150000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule